// File: doc/BRIEF.md
# Cascadable Serial Configuration Bit Memory

This block is the read side of a one-time-programmable memory that hands a configuration bitstream to a loader one bit per clock. The bit image is fixed when the design is elaborated and is computed from two parameters. An internal address counter walks the image. A single input serves as both reset and output enable, and a parameter chooses its active level. The data bit comes out with its own drive-enable flag, so the shared line is modelled without a real tri-state.

Several instances can share one clock and one data line and form a single longer stream. Each device's chain-enable output feeds the active-low chip enable of the next device. Once a device has passed its last address, its counter stops and it drops its drive. On that same clock edge its chain-enable output goes low, so the next device starts driving on the following bit. A standby flag reports when chip enable is inactive.

Top module: `serial_cfg_rom`

## Requirements
- R1: On each rising clock edge with chip enable low and the reset/enable input inactive, the address advances by one. After reset is released, the first bit presented is the bit at address 0.
- R2: While the reset/enable input is active, the address is held at zero, `data_oe` is 0 and `chain_ce_n` is 1.
- R3: With `RST_ACTIVE_HIGH`=1 a high level on `rst_oe` is reset. With `RST_ACTIVE_HIGH`=0 a low level is reset.
- R4: While `ce_n` is 1, the address does not change, `data_oe` is 0 whatever `rst_oe` is, and `standby` is 1.
- R5: After the last address (`DEPTH`-1) has been read, further clocks leave the counter frozen. It does not wrap back to address 0, and `data_oe` stays 0.
- R6: On the rising edge that follows the read of the last bit, `chain_ce_n` goes low and `data_oe` goes to 0.
- R7: Once readout is complete, `chain_ce_n` follows `ce_n` for as long as reset stays inactive.
- R8: The bit stored at address a equals the XOR of the bits of (a[15:0] AND `IMG_KEY`[15:0]), XOR-ed with `IMG_INV`.
- R9: `data` is 0 whenever `data_oe` is 0.
- R10: When two devices are chained through `chain_ce_n`, the combined line carries all of the first image and then all of the second, and at most one device drives at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; data changes after each rising edge |
| ce_n | input | 1 | Active-low chip enable |
| rst_oe | input | 1 | Combined reset / output enable; active level set by `RST_ACTIVE_HIGH` |
| data | output | 1 | Serial data bit, 0 when not driven |
| data_oe | output | 1 | High when this device drives the shared line |
| chain_ce_n | output | 1 | Active-low enable for the next device in the chain |
| standby | output | 1 | High while chip enable is inactive |

## Verification
The assertions assume that `ce_n` and `rst_oe` change only away from the rising clock edge. They also assume that reset is applied before the first edge, so the counter and the past-terminal flag start from known values. The bench changes every input on the falling edge, holds reset active from time zero, and drives the second device's chip enable only from the first device's chain output. This keeps the hand-off edge free of any setup race.

// File: rtl/serial_cfg_rom.sv
module serial_cfg_rom #(
  parameter int          DEPTH           = 2048,
  parameter bit          RST_ACTIVE_HIGH = 1'b1,
  parameter logic [15:0] IMG_KEY         = 16'h00B5,
  parameter bit          IMG_INV         = 1'b0
) (
  input  logic clk,
  input  logic ce_n,
  input  logic rst_oe,
  output logic data,
  output logic data_oe,
  output logic chain_ce_n,
  output logic standby
);

  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

  function automatic logic [DEPTH-1:0] build_image();
    logic [DEPTH-1:0] img;
    for (int a = 0; a < DEPTH; a++) begin
      logic [15:0] av;
      av = a[15:0];
      img[a] = (^(av & IMG_KEY)) ^ IMG_INV;
    end
    return img;
  endfunction

  localparam logic [DEPTH-1:0] IMAGE = build_image();

  logic              rst_act;
  logic              enabled;
  logic [ADDR_W-1:0] addr;
  logic              past_tc;

  assign rst_act = RST_ACTIVE_HIGH ? rst_oe : ~rst_oe;
  assign enabled = ~ce_n & ~rst_act;

  always_ff @(posedge clk or posedge rst_act) begin
    if (rst_act) begin
      addr    <= '0;
      past_tc <= 1'b0;
    end else if (enabled && !past_tc) begin
      if (addr == LAST_ADDR) past_tc <= 1'b1;
      else                   addr    <= addr + ADDR_W'(1);
    end
  end

  assign data_oe    = enabled & ~past_tc;
  assign data       = data_oe & IMAGE[addr];
  assign chain_ce_n = ~(enabled & past_tc);
  assign standby    = ce_n;

  AST_ADVANCE: assert property (@(posedge clk) disable iff (rst_act)
    (enabled && !past_tc && addr != LAST_ADDR) |=> (addr == $past(addr) + ADDR_W'(1))); // R1
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst_act)
    ce_n |=> ($stable(addr) && $stable(past_tc))); // R4
  AST_FROZEN: assert property (@(posedge clk) disable iff (rst_act)
    past_tc |=> (past_tc && $stable(addr))); // R5
  AST_HANDOFF: assert property (@(posedge clk) disable iff (rst_act)
    (enabled && addr == LAST_ADDR && !past_tc) |=> (!data_oe || ce_n)); // R6
  AST_CHAIN_DONE: assert property (@(posedge clk) disable iff (rst_act)
    !chain_ce_n |-> (past_tc && !ce_n && !data_oe)); // R7

  always_comb begin
    if (!rst_act) begin
      AST_QUIET_LINE: assert (data_oe || !data); // R9
    end
  end

endmodule

// File: tb/test_serial_cfg_rom.sv
module test_serial_cfg_rom;
  localparam int CLK_PERIOD = 10;
  localparam int D0 = 37;
  localparam int D1 = 23;
  localparam int DC = 11;
  localparam logic [15:0] K0 = 16'h00B5;
  localparam logic [15:0] K1 = 16'h0036;
  localparam logic [15:0] KC = 16'h0003;

  logic clk = 1'b0;
  logic rst_hi = 1'b1;
  logic rst_lo = 1'b0;
  logic ce0_n = 1'b0;
  logic cec_n = 1'b0;
  logic d0, oe0, ch0, sb0;
  logic d1, oe1, ch1, sb1;
  logic dc, oec, chc, sbc;
  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_cfg_rom #(.DEPTH(D0), .RST_ACTIVE_HIGH(1'b1), .IMG_KEY(K0), .IMG_INV(1'b0)) i_serial_cfg_rom (
    .clk(clk), .ce_n(ce0_n), .rst_oe(rst_hi), .data(d0), .data_oe(oe0), .chain_ce_n(ch0), .standby(sb0));
  serial_cfg_rom #(.DEPTH(D1), .RST_ACTIVE_HIGH(1'b1), .IMG_KEY(K1), .IMG_INV(1'b1)) i_second (
    .clk(clk), .ce_n(ch0), .rst_oe(rst_hi), .data(d1), .data_oe(oe1), .chain_ce_n(ch1), .standby(sb1));
  serial_cfg_rom #(.DEPTH(DC), .RST_ACTIVE_HIGH(1'b0), .IMG_KEY(KC), .IMG_INV(1'b0)) i_lowpol (
    .clk(clk), .ce_n(cec_n), .rst_oe(rst_lo), .data(dc), .data_oe(oec), .chain_ce_n(chc), .standby(sbc));

  wire line = (oe0 & d0) | (oe1 & d1);

  function automatic logic img_bit(logic [15:0] key, logic inv, int a);
    logic [15:0] av;
    av = a[15:0];
    return (^(av & key)) ^ inv;
  endfunction

  function automatic logic stream_bit(int k);
    if (k < D0) return img_bit(K0, 1'b0, k);
    return img_bit(K1, 1'b1, k - D0);
  endfunction

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) step();
    check("R2 oe0", oe0, 1'b0);
    check("R2 oe1", oe1, 1'b0);
    check("R2 chain0", ch0, 1'b1);
    check("R2 chain1", ch1, 1'b1);
    check("R9 data0", d0, 1'b0);
    check("R3 low-level reset oe", oec, 1'b0);
    check("R4 standby0 low", sb0, 1'b0);

    @(negedge clk); rst_hi = 1'b0; #1;
    for (int k = 0; k < D0 + D1; k++) begin
      if (k == 5) begin
        ce0_n = 1'b1; #1;
        repeat (3) begin
          check("R4 standby", sb0, 1'b1);
          check("R4 oe0 off", oe0, 1'b0);
          check("R10 second idle", oe1, 1'b0);
          step();
          ce0_n = 1'b1;
        end
        ce0_n = 1'b0; #1;
      end
      check("R10 one driver", logic'((oe0 + oe1) == 1), 1'b1);
      check("R8 R1 stream", line, stream_bit(k));
      if (!oe0) check("R9 quiet", d0, 1'b0);
      if (k == D0) check("R6 handoff chain0", ch0, 1'b0);
      step();
    end
    check("R6 oe0 off", oe0, 1'b0);
    check("R6 oe1 off", oe1, 1'b0);
    check("R6 chain1 low", ch1, 1'b0);
    repeat (5) step();
    check("R5 frozen oe0", oe0, 1'b0);
    check("R5 frozen oe1", oe1, 1'b0);
    check("R5 chain0 kept", ch0, 1'b0);

    @(negedge clk); ce0_n = 1'b1; #1;
    check("R7 chain follows high", ch0, 1'b1);
    check("R7 chain1 follows", ch1, 1'b1);
    step();
    @(negedge clk); ce0_n = 1'b0; #1;
    check("R7 chain follows low", ch0, 1'b0);
    check("R5 no wrap", oe0, 1'b0);

    @(negedge clk); rst_hi = 1'b1; #1;
    check("R2 mid oe0", oe0, 1'b0);
    check("R2 mid chain0", ch0, 1'b1);
    step();
    @(negedge clk); rst_hi = 1'b0; #1;
    check("R1 restart oe0", oe0, 1'b1);
    check("R1 restart bit0", line, stream_bit(0));
    step();
    check("R1 restart bit1", line, stream_bit(1));

    @(negedge clk); rst_lo = 1'b1; #1;
    check("R3 high releases", oec, 1'b1);
    check("R3 bit0", dc, img_bit(KC, 1'b0, 0));
    step(); step();
    check("R3 bit2", dc, img_bit(KC, 1'b0, 2));
    @(negedge clk); rst_lo = 1'b0; #1;
    check("R3 low resets", oec, 1'b0);
    check("R3 chain high", chc, 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule